// File: doc/BRIEF.md
# Shared-Bus Register Datapath

This block is the register-and-bus half of a small accumulator machine. Six source registers and a word memory each have a fixed three-bit code. The code on `bus_sel` picks which one drives a single 16-bit bus. Seven registers can capture that bus, and each one has its own load, increment and clear strobes. The memory writes the bus value at the location named by the address register. A sequencer outside the block drives all of these strobes.

The address and program-counter registers are 12 bits wide. The output register is 8 bits wide. The data, accumulator, instruction and temporary registers are 16 bits wide. A narrow source reaches the bus with zeros above its top bit. A narrow destination keeps only the low bus bits. All register contents appear on output ports, and so does the live bus value. A transfer between registers takes one clock edge and does not change the source.

Top module: `bus_datapath`

## Requirements
- R1: The bus is driven by code value. 1 selects the address register, 2 the program counter, 3 the data register, 4 the accumulator, 5 the instruction register and 6 the temporary register. Code 7 selects the memory word at the address register, but only while `mem_rd` is 1. Code 0, and code 7 with `mem_rd` at 0, put all zeros on the bus.
- R2: A 12-bit source appears on the bus with bits 15:12 at zero.
- R3: A register whose load strobe is 1 captures the bus on the next rising clock edge. A 12-bit register takes bus bits 11:0 and the 8-bit register takes bus bits 7:0.
- R4: Placing a register on the bus for a transfer does not change that register.
- R5: When a source register is loaded, incremented or cleared in the same cycle that another register loads it from the bus, the destination receives the value the source held before the edge.
- R6: An increment strobe adds one, modulo 2 to the power of the register width. For example, 12'hFFF goes to 0, 16'hFFFF goes to 0 and 8'hFF goes to 0.
- R7: A clear strobe forces the register to zero on the next edge.
- R8: On one register, clear wins over load and load wins over increment.
- R9: With `mem_wr` at 1, the bus value is stored into the memory word addressed by the address register on the rising edge. With `mem_wr` at 0, memory is unchanged.
- R10: A synchronous active-high reset zeroes every register. It leaves the memory contents alone.
- R11: A register with all three strobes at 0 keeps its value.

Register strobe bit order in `reg_ld`, `reg_inc` and `reg_clr`: bit 0 address, 1 program counter, 2 data, 3 accumulator, 4 instruction, 5 temporary, 6 output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 3 | Bus source code |
| reg_ld | input | 7 | Per-register load strobes |
| reg_inc | input | 7 | Per-register increment strobes |
| reg_clr | input | 7 | Per-register clear strobes |
| mem_wr | input | 1 | Memory write strobe |
| mem_rd | input | 1 | Memory read enable for code 7 |
| bus_value | output | 16 | Current bus value |
| ar_q | output | 12 | Address register |
| pc_q | output | 12 | Program counter |
| dr_q | output | 16 | Data register |
| ac_q | output | 16 | Accumulator |
| ir_q | output | 16 | Instruction register |
| tr_q | output | 16 | Temporary register |
| outr_q | output | 8 | Output register |

## Verification
The bench drives the accumulator onto the bus while also incrementing it. A design that sampled the source after the edge would hand the destination the incremented value. It asserts all three strobes on one register and then load with increment. A wrong priority shows up as a stale, loaded or incremented value where zero or the bus value is expected. Code 7 is read with `mem_rd` low and memory is read back after a reset, which catches a read gate that leaks and a reset that wipes memory. It also walks the address register to 12'hFFF and the data register to 16'hFFFF. This exposes a bus that sign-extends or leaks stale upper bits, a narrow load that keeps the wrong slice, and an increment that fails to wrap.

// File: rtl/bdp_pkg.sv
package bdp_pkg;
  localparam int NREG = 7;
  localparam int NSRC = 6;
  localparam int SEL_W = 3;

  localparam int IDX_AR  = 0;
  localparam int IDX_PC  = 1;
  localparam int IDX_DR  = 2;
  localparam int IDX_AC  = 3;
  localparam int IDX_IR  = 4;
  localparam int IDX_TR  = 5;
  localparam int IDX_OUT = 6;

  localparam logic [SEL_W-1:0] SEL_NONE = 3'd0;
  localparam logic [SEL_W-1:0] SEL_AR   = 3'd1;
  localparam logic [SEL_W-1:0] SEL_PC   = 3'd2;
  localparam logic [SEL_W-1:0] SEL_AC   = 3'd4;
  localparam logic [SEL_W-1:0] SEL_MEM  = 3'd7;
endpackage

// File: rtl/bdp_reg.sv
module bdp_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         ld,
  input  logic         inc,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)      q <= '0;
    else if (clr) q <= '0;
    else if (ld)  q <= d;
    else if (inc) q <= q + 1'b1;
  end

  p_reset_r10: assert property (@(posedge clk) rst |=> q == '0);
  p_clear_r7:  assert property (@(posedge clk) disable iff (rst) clr |=> q == '0);
  p_load_r3:   assert property (@(posedge clk) disable iff (rst) (ld && !clr) |=> q == $past(d));
  p_prio_r8:   assert property (@(posedge clk) disable iff (rst) (ld && inc && !clr) |=> q == $past(d));
  p_inc_r6:    assert property (@(posedge clk) disable iff (rst)
                 (inc && !ld && !clr) |=> q == $past(q) + 1'b1);
  p_hold_r11:  assert property (@(posedge clk) disable iff (rst) (!inc && !ld && !clr) |=> $stable(q));
endmodule

// File: rtl/bdp_bus_mux.sv
module bdp_bus_mux
  import bdp_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [SEL_W-1:0]             sel,
  input  logic                         mem_rd,
  input  logic [NSRC-1:0][DATA_W-1:0]  src,
  input  logic [DATA_W-1:0]            mem_word,
  output logic [DATA_W-1:0]            bus
);
  always_comb begin
    bus = '0;
    for (int k = 0; k < NSRC; k++) begin
      if (sel == SEL_W'(k + 1)) bus = src[k];
    end
    if (sel == SEL_MEM && mem_rd) bus = mem_word;
  end
endmodule

// File: rtl/bdp_mem.sv
module bdp_mem #(
  parameter int AW = 10,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[addr] <= wdata;
  end

  assign rdata = store[addr];

  p_mem_write_r9: assert property (@(posedge clk) disable iff (rst)
                    we |=> store[$past(addr)] == $past(wdata));
endmodule

// File: rtl/bus_datapath.sv
module bus_datapath
  import bdp_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12,
  parameter int IO_W   = 8,
  parameter int MEM_AW = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        bus_sel,
  input  logic [6:0]        reg_ld,
  input  logic [6:0]        reg_inc,
  input  logic [6:0]        reg_clr,
  input  logic              mem_wr,
  input  logic              mem_rd,
  output logic [15:0]       bus_value,
  output logic [11:0]       ar_q,
  output logic [11:0]       pc_q,
  output logic [15:0]       dr_q,
  output logic [15:0]       ac_q,
  output logic [15:0]       ir_q,
  output logic [15:0]       tr_q,
  output logic [7:0]        outr_q
);
  logic [NREG-1:0][DATA_W-1:0] reg_ext;
  logic [DATA_W-1:0]           bus;
  logic [DATA_W-1:0]           mem_word;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam int W = (g == IDX_AR || g == IDX_PC) ? ADDR_W :
                       (g == IDX_OUT) ? IO_W : DATA_W;
    logic [W-1:0] q;
    bdp_reg #(.W(W)) u_reg (
      .clk (clk),
      .rst (rst),
      .clr (reg_clr[g]),
      .ld  (reg_ld[g]),
      .inc (reg_inc[g]),
      .d   (bus[W-1:0]),
      .q   (q)
    );
    assign reg_ext[g] = DATA_W'(q);
  end

  bdp_bus_mux #(.DATA_W(DATA_W)) u_mux (
    .sel      (bus_sel),
    .mem_rd   (mem_rd),
    .src      (reg_ext[NSRC-1:0]),
    .mem_word (mem_word),
    .bus      (bus)
  );

  bdp_mem #(.AW(MEM_AW), .DW(DATA_W)) u_mem (
    .clk   (clk),
    .rst   (rst),
    .we    (mem_wr),
    .addr  (reg_ext[IDX_AR][MEM_AW-1:0]),
    .wdata (bus),
    .rdata (mem_word)
  );

  assign bus_value = bus;
  assign ar_q   = reg_ext[IDX_AR][ADDR_W-1:0];
  assign pc_q   = reg_ext[IDX_PC][ADDR_W-1:0];
  assign dr_q   = reg_ext[IDX_DR];
  assign ac_q   = reg_ext[IDX_AC];
  assign ir_q   = reg_ext[IDX_IR];
  assign tr_q   = reg_ext[IDX_TR];
  assign outr_q = reg_ext[IDX_OUT][IO_W-1:0];

  p_zext_r2: assert property (@(posedge clk) disable iff (rst)
               (bus_sel == SEL_AR || bus_sel == SEL_PC) |-> bus_value[DATA_W-1:ADDR_W] == '0);
  p_rd_gate_r1: assert property (@(posedge clk) disable iff (rst)
               ((bus_sel == SEL_MEM && !mem_rd) || bus_sel == SEL_NONE) |-> bus_value == '0);
  p_swap_r5: assert property (@(posedge clk) disable iff (rst)
               (bus_sel == SEL_AC && reg_ld[IDX_DR] && !reg_clr[IDX_DR]) |=> dr_q == $past(ac_q));
endmodule

// File: tb/bus_datapath_tb.sv
`timescale 1ns/1ps
module bus_datapath_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  bus_sel = '0;
  logic [6:0]  reg_ld = '0, reg_inc = '0, reg_clr = '0;
  logic        mem_wr = 1'b0, mem_rd = 1'b0;
  logic [15:0] bus_value, dr_q, ac_q, ir_q, tr_q;
  logic [11:0] ar_q, pc_q;
  logic [7:0]  outr_q;
  logic [15:0] last_bus;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  bus_datapath u_dut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .reg_ld(reg_ld), .reg_inc(reg_inc),
    .reg_clr(reg_clr), .mem_wr(mem_wr), .mem_rd(mem_rd), .bus_value(bus_value),
    .ar_q(ar_q), .pc_q(pc_q), .dr_q(dr_q), .ac_q(ac_q), .ir_q(ir_q), .tr_q(tr_q),
    .outr_q(outr_q)
  );

  // fields: req(4) sel(3) ld(7) inc(7) clr(7) wr rd chk(3) exp(16) bus(16)
  // strobe masks: 01 AR, 02 PC, 04 DR, 08 AC, 10 IR, 20 TR, 40 OUTR
  localparam int NV = 29;
  localparam logic [64:0] VEC [NV] = '{
    {4'd6, 3'd0,7'h00,7'h08,7'h00,2'b00,3'd3,16'd1,16'd0}, // R6 AC++
    {4'd6, 3'd0,7'h00,7'h08,7'h00,2'b00,3'd3,16'd2,16'd0}, // R6
    {4'd3, 3'd4,7'h04,7'h00,7'h00,2'b00,3'd2,16'd2,16'd2}, // R3 DR<-AC
    {4'd6, 3'd0,7'h00,7'h04,7'h00,2'b00,3'd2,16'd3,16'd0}, // R6
    {4'd3, 3'd3,7'h28,7'h00,7'h00,2'b00,3'd5,16'd3,16'd3}, // R3 AC,TR<-DR
    {4'd11,3'd0,7'h00,7'h00,7'h00,2'b00,3'd3,16'd3,16'd0}, // R11 hold
    {4'd6, 3'd0,7'h00,7'h08,7'h00,2'b00,3'd3,16'd4,16'd0}, // R6
    {4'd5, 3'd4,7'h04,7'h08,7'h00,2'b00,3'd2,16'd4,16'd4}, // R5 DR gets old AC
    {4'd5, 3'd0,7'h00,7'h00,7'h00,2'b00,3'd3,16'd5,16'd0}, // R5 AC did increment
    {4'd3, 3'd3,7'h10,7'h00,7'h00,2'b00,3'd4,16'd4,16'd4}, // R3 IR<-DR
    {4'd4, 3'd0,7'h00,7'h00,7'h00,2'b00,3'd2,16'd4,16'd0}, // R4 DR unchanged
    {4'd8, 3'd4,7'h20,7'h20,7'h20,2'b00,3'd5,16'd0,16'd5}, // R8 clear wins
    {4'd8, 3'd4,7'h20,7'h20,7'h00,2'b00,3'd5,16'd5,16'd5}, // R8 load beats inc
    {4'd6, 3'd0,7'h00,7'h20,7'h00,2'b00,3'd5,16'd6,16'd0}, // R6
    {4'd6, 3'd0,7'h00,7'h01,7'h00,2'b00,3'd0,16'd1,16'd0}, // R6 AR=1
    {4'd11,3'd4,7'h00,7'h00,7'h00,2'b10,3'd3,16'd5,16'd5}, // R11 M[1]=5
    {4'd6, 3'd0,7'h00,7'h01,7'h00,2'b00,3'd0,16'd2,16'd0}, // R6 AR=2
    {4'd9, 3'd6,7'h00,7'h00,7'h00,2'b10,3'd5,16'd6,16'd6}, // R9 M[2]=6
    {4'd7, 3'd0,7'h00,7'h00,7'h01,2'b00,3'd0,16'd0,16'd0}, // R7 clear AR
    {4'd6, 3'd0,7'h00,7'h01,7'h00,2'b00,3'd0,16'd1,16'd0}, // R6
    {4'd9, 3'd7,7'h04,7'h00,7'h00,2'b01,3'd2,16'd5,16'd5}, // R9 read M[1]
    {4'd1, 3'd7,7'h04,7'h00,7'h00,2'b00,3'd2,16'd0,16'd0}, // R1 gated read
    {4'd6, 3'd0,7'h00,7'h01,7'h00,2'b00,3'd0,16'd2,16'd0}, // R6
    {4'd3, 3'd7,7'h40,7'h00,7'h00,2'b01,3'd6,16'd6,16'd6}, // R3 OUTR<-M[2]
    {4'd6, 3'd0,7'h00,7'h02,7'h00,2'b00,3'd1,16'd1,16'd0}, // R6 PC++
    {4'd1, 3'd2,7'h08,7'h00,7'h00,2'b00,3'd3,16'd1,16'd1}, // R1 PC on bus
    {4'd2, 3'd1,7'h10,7'h00,7'h00,2'b00,3'd4,16'd2,16'd2}, // R2 AR on bus
    {4'd11,3'd4,7'h00,7'h00,7'h00,2'b00,3'd3,16'd1,16'd1}, // R11
    {4'd9, 3'd7,7'h20,7'h00,7'h00,2'b01,3'd5,16'd6,16'd6}  // R9 no write left M[2]
  };

  function automatic logic [15:0] get_reg(input logic [2:0] idx);
    case (idx)
      3'd0: get_reg = {4'h0, ar_q};
      3'd1: get_reg = {4'h0, pc_q};
      3'd2: get_reg = dr_q;
      3'd3: get_reg = ac_q;
      3'd4: get_reg = ir_q;
      3'd5: get_reg = tr_q;
      default: get_reg = {8'h00, outr_q};
    endcase
  endfunction

  task automatic check(input int req, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // called at a negedge; returns at the following negedge
  task automatic cyc(input logic [2:0] s, input logic [6:0] l, input logic [6:0] i,
                     input logic [6:0] c, input logic w, input logic r);
    bus_sel = s; reg_ld = l; reg_inc = i; reg_clr = c; mem_wr = w; mem_rd = r;
    #1 last_bus = bus_value;
    @(negedge clk);
    bus_sel = '0; reg_ld = '0; reg_inc = '0; reg_clr = '0; mem_wr = 1'b0; mem_rd = 1'b0;
  endtask

  task automatic check_all_zero(input int req);
    for (int k = 0; k < 7; k++) check(req, "reset value", get_reg(3'(k)), 16'h0000);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check_all_zero(10); // R10 reset state

    for (int v = 0; v < NV; v++) begin
      logic [64:0] e;
      e = VEC[v];
      cyc(e[60:58], e[57:51], e[50:44], e[43:37], e[36], e[35]);
      check(1, "bus value (R1)", last_bus, e[15:0]);
      check(int'(e[64:61]), "register after vector", get_reg(e[34:32]), e[31:16]);
    end

    // R10: reset mid-run, memory kept
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check_all_zero(10);
    cyc(3'd0, 7'h00, 7'h01, 7'h00, 1'b0, 1'b0);
    cyc(3'd0, 7'h00, 7'h01, 7'h00, 1'b0, 1'b0);
    cyc(3'd7, 7'h00, 7'h00, 7'h00, 1'b0, 1'b1);
    check(10, "memory after reset", last_bus, 16'd6);

    // R6 / R2: address register to 12'hFFF
    cyc(3'd0, 7'h00, 7'h00, 7'h01, 1'b0, 1'b0);
    for (int n = 0; n < 4095; n++) cyc(3'd0, 7'h00, 7'h01, 7'h00, 1'b0, 1'b0);
    check(6, "AR count", {4'h0, ar_q}, 16'h0FFF);
    cyc(3'd1, 7'h04, 7'h00, 7'h00, 1'b0, 1'b0);
    check(2, "AR zero-extended on bus", last_bus, 16'h0FFF);
    check(3, "DR from AR", dr_q, 16'h0FFF);
    cyc(3'd0, 7'h00, 7'h01, 7'h00, 1'b0, 1'b0);
    check(6, "AR wrap", {4'h0, ar_q}, 16'h0000);

    // R6 / R3: data register to 16'hFFFF, narrow loads, wraps
    for (int n = 0; n < 16'hF000; n++) cyc(3'd0, 7'h00, 7'h04, 7'h00, 1'b0, 1'b0);
    check(6, "DR count", dr_q, 16'hFFFF);
    cyc(3'd3, 7'h49, 7'h00, 7'h00, 1'b0, 1'b0);
    check(3, "AR takes low 12 bits", {4'h0, ar_q}, 16'h0FFF);
    check(3, "OUTR takes low 8 bits", {8'h00, outr_q}, 16'h00FF);
    check(3, "AC full width", ac_q, 16'hFFFF);
    check(4, "DR unchanged by transfer", dr_q, 16'hFFFF);
    cyc(3'd0, 7'h00, 7'h44, 7'h00, 1'b0, 1'b0);
    check(6, "DR wrap", dr_q, 16'h0000);
    check(6, "OUTR wrap", {8'h00, outr_q}, 16'h0000);
    cyc(3'd0, 7'h00, 7'h00, 7'h08, 1'b0, 1'b0);
    check(7, "AC clear", ac_q, 16'h0000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule